// File: doc/BRIEF.md
# Registered Bidirectional Pad Cell

This block models a bidirectional pad cell. The core hands it transmit data and an output-enable bit. The pad carries that data outward while the enable is set. The pad value always returns to the core on the receive output. Three storage stages sit on these paths: transmit data, receive data and output enable. Each stage has its own clock, and a parameter can remove any one of them, which turns that path into plain wiring.

The two data stages start from a reset value set by a parameter. A reset-style parameter picks one of two schemes for both data stages together. In the asynchronous scheme, each stage has its own active-low clear. In the synchronous scheme, a single shared active-low reset loads the value on the next clock edge, and the per-stage clears are ignored. The enable stage always clears asynchronously. Data-enable inputs gate capture. A parameter decides whether the receive stage has its own enable or follows the transmit enable.

Top module: `bidir_io_cell`

## Requirements
- R1: The transmit, receive and enable stages capture only on the rising edge of txClk, rxClk and oeClk respectively; an edge on one clock leaves the other two stages unchanged.
- R2: While the effective output enable is 1 the cell drives pad with the effective transmit value; while it is 0 the cell releases pad, so a value driven from outside appears on rxData.
- R3: While oeRstN is low the enable stage is cleared at once, and it ignores oeClk edges; pad is released.
- R4: With SYNC_RST=0, a low on txRstN sets the transmit stage to RST_VAL at once, and a low on rxRstN sets the receive stage to RST_VAL at once, without any clock edge.
- R5: With SYNC_RST=0, syncRstN has no effect on either data stage.
- R6: With SYNC_RST=1, syncRstN low loads RST_VAL into each data stage on that stage's next rising clock edge, and does not change it before that edge.
- R7: With SYNC_RST=1, txRstN and rxRstN have no effect on the data stages.
- R8: A data stage loads new data only on an edge where its enable is 1 and holds its value otherwise; reset wins over the enable.
- R9: With SPLIT_EN=1, the receive stage is enabled by rxEn. With SPLIT_EN=0, the receive stage is enabled by txEn and rxEn is ignored.
- R10: With TX_BYPASS, RX_BYPASS and OE_BYPASS set, txData, oeIn and the pad value pass through to pad, the driver enable and rxData with no clock edge.
- R11: When all three stages are registered and the enable is 1, a word placed on txData reaches pad one txClk edge later and rxData one rxClk edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit stage clock |
| rxClk | input | 1 | Receive stage clock |
| oeClk | input | 1 | Output-enable stage clock |
| txRstN | input | 1 | Asynchronous clear of the transmit stage (asynchronous scheme) |
| rxRstN | input | 1 | Asynchronous clear of the receive stage (asynchronous scheme) |
| oeRstN | input | 1 | Asynchronous clear of the enable stage |
| syncRstN | input | 1 | Shared synchronous reset of both data stages (synchronous scheme) |
| txEn | input | 1 | Transmit capture enable; also the receive enable when SPLIT_EN=0 |
| rxEn | input | 1 | Receive capture enable when SPLIT_EN=1 |
| txData | input | W | Data to send out on the pad |
| oeIn | input | 1 | Output enable request, active high |
| rxData | output | W | Pad value returned to the core |
| pad | inout | W | Bidirectional pad |

## Verification
The hardest point to reach is pad release. When the cell stops driving, the only visible sign is the pad value that comes back to the core, and that path may itself be registered. The bench drives a different word onto the pad whenever its own model says the enable is low. It then moves that word through the receive stage with a separate rxClk pulse. A cell that kept driving would mix its transmit word into the result. Three instances run from the same stimulus: asynchronous with split enables, synchronous with a shared enable, and fully bypassed. Each clock is pulsed by itself, so every stage can be seen changing, or holding, on its own.

// File: rtl/bidir_io_pkg.sv
package bidir_io_pkg;
  typedef struct packed {
    logic txArstN;
    logic rxArstN;
    logic dataSrst;
    logic txLoad;
    logic rxLoad;
    logic oeArstN;
  } ioStrobes_t;
endpackage

// File: rtl/bidir_io_ctrl.sv
module bidir_io_ctrl
  import bidir_io_pkg::*;
#(
  parameter bit SYNC_RST = 1'b0,
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic       txRstN,
  input  logic       rxRstN,
  input  logic       oeRstN,
  input  logic       syncRstN,
  input  logic       txEn,
  input  logic       rxEn,
  output ioStrobes_t strb
);
  always_comb begin
    strb.txArstN  = SYNC_RST ? 1'b1 : txRstN;
    strb.rxArstN  = SYNC_RST ? 1'b1 : rxRstN;
    strb.dataSrst = SYNC_RST ? ~syncRstN : 1'b0;
    strb.txLoad   = txEn;
    strb.rxLoad   = SPLIT_EN ? rxEn : txEn;
    strb.oeArstN  = oeRstN;
  end
endmodule

// File: rtl/bidir_io_dreg.sv
module bidir_io_dreg #(
  parameter int              W        = 4,
  parameter logic [W-1:0]    RST_VAL  = '0,
  parameter bit              SYNC_RST = 1'b0,
  parameter bit              BYPASS   = 1'b0
) (
  input  logic         clk,
  input  logic         arstN,
  input  logic         srst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (BYPASS) begin : g_byp
    logic unusedPins;
    assign unusedPins = &{1'b0, clk, arstN, srst, load};
    assign q = d;
  end else if (SYNC_RST) begin : g_sync
    logic unusedPins;
    assign unusedPins = &{1'b0, arstN};
    always_ff @(posedge clk) begin
      if (srst)      q <= RST_VAL;
      else if (load) q <= d;
    end
    // R6
    sync_load_chk: assert property (@(posedge clk) disable iff (!arstN)
      srst |=> q == RST_VAL);
    // R8
    enabled_capture_chk: assert property (@(posedge clk) disable iff (!arstN)
      (!srst && load) |=> q == $past(d));
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!arstN)
      (!srst && !load) |=> $stable(q));
  end else begin : g_async
    logic unusedPins;
    assign unusedPins = &{1'b0, srst};
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN)    q <= RST_VAL;
      else if (load) q <= d;
    end
    // R4
    async_held_chk: assert property (@(posedge clk) disable iff (srst)
      !arstN |-> q == RST_VAL);
  end
endmodule

// File: rtl/bidir_io_dpath.sv
module bidir_io_dpath
  import bidir_io_pkg::*;
#(
  parameter int           W         = 4,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter bit           SYNC_RST  = 1'b0,
  parameter bit           TX_BYPASS = 1'b0,
  parameter bit           RX_BYPASS = 1'b0,
  parameter bit           OE_BYPASS = 1'b0
) (
  input  logic         txClk,
  input  logic         rxClk,
  input  logic         oeClk,
  input  ioStrobes_t   strb,
  input  logic [W-1:0] txData,
  input  logic         oeIn,
  output logic [W-1:0] rxData,
  inout  wire  [W-1:0] pad
);
  logic [W-1:0] txEff;
  logic [W-1:0] padIn;
  logic         oeEff;

  bidir_io_dreg #(.W(W), .RST_VAL(RST_VAL), .SYNC_RST(SYNC_RST), .BYPASS(TX_BYPASS)) u_txReg (
    .clk(txClk), .arstN(strb.txArstN), .srst(strb.dataSrst),
    .load(strb.txLoad), .d(txData), .q(txEff)
  );

  bidir_io_dreg #(.W(W), .RST_VAL(RST_VAL), .SYNC_RST(SYNC_RST), .BYPASS(RX_BYPASS)) u_rxReg (
    .clk(rxClk), .arstN(strb.rxArstN), .srst(strb.dataSrst),
    .load(strb.rxLoad), .d(padIn), .q(rxData)
  );

  if (OE_BYPASS) begin : g_oeByp
    logic unusedPins;
    assign unusedPins = &{1'b0, oeClk, strb.oeArstN};
    assign oeEff = oeIn;
  end else begin : g_oeReg
    always_ff @(posedge oeClk or negedge strb.oeArstN) begin
      if (!strb.oeArstN) oeEff <= 1'b0;
      else               oeEff <= oeIn;
    end
  end

  assign pad   = oeEff ? txEff : 'z;
  assign padIn = pad;

  // R2
  pad_follows_tx_chk: assert property (@(posedge txClk) disable iff (!strb.oeArstN)
    (oeEff === 1'b1) |-> (pad === txEff));
endmodule

// File: rtl/bidir_io_cell.sv
module bidir_io_cell
  import bidir_io_pkg::*;
#(
  parameter int           W         = 4,
  parameter logic [W-1:0] RST_VAL   = 4'hA,
  parameter bit           SYNC_RST  = 1'b0,
  parameter bit           SPLIT_EN  = 1'b1,
  parameter bit           TX_BYPASS = 1'b0,
  parameter bit           RX_BYPASS = 1'b0,
  parameter bit           OE_BYPASS = 1'b0
) (
  input  logic         txClk,
  input  logic         rxClk,
  input  logic         oeClk,
  input  logic         txRstN,
  input  logic         rxRstN,
  input  logic         oeRstN,
  input  logic         syncRstN,
  input  logic         txEn,
  input  logic         rxEn,
  input  logic [W-1:0] txData,
  input  logic         oeIn,
  output logic [W-1:0] rxData,
  inout  wire  [W-1:0] pad
);
  ioStrobes_t strb;

  bidir_io_ctrl #(.SYNC_RST(SYNC_RST), .SPLIT_EN(SPLIT_EN)) u_ctrl (
    .txRstN(txRstN), .rxRstN(rxRstN), .oeRstN(oeRstN), .syncRstN(syncRstN),
    .txEn(txEn), .rxEn(rxEn), .strb(strb)
  );

  bidir_io_dpath #(
    .W(W), .RST_VAL(RST_VAL), .SYNC_RST(SYNC_RST),
    .TX_BYPASS(TX_BYPASS), .RX_BYPASS(RX_BYPASS), .OE_BYPASS(OE_BYPASS)
  ) u_dpath (
    .txClk(txClk), .rxClk(rxClk), .oeClk(oeClk), .strb(strb),
    .txData(txData), .oeIn(oeIn), .rxData(rxData), .pad(pad)
  );
endmodule

// File: tb/bidir_io_cell_tb.sv
module bidir_io_cell_tb;
  localparam int           CLK_PERIOD = 10;
  localparam int           W          = 4;
  localparam logic [W-1:0] RV         = 4'hA;

  logic txClk = 0, rxClk = 0, oeClk = 0;
  logic txRstN = 1, rxRstN = 1, oeRstN = 1, syncRstN = 1;
  logic txEn = 0, rxEn = 0, oeIn = 0;
  logic [W-1:0] txData = '0;
  logic [W-1:0] tbPadVal = '0;
  logic tbDrvReg = 1;
  logic [W-1:0] rxA, rxB, rxC;
  wire  [W-1:0] padA, padB, padC;
  int checks = 0, fails = 0;
  bit done = 0;

  assign padA = tbDrvReg ? tbPadVal : 'z;
  assign padB = tbDrvReg ? tbPadVal : 'z;
  assign padC = oeIn ? 'z : tbPadVal;

  bidir_io_cell #(.W(W), .RST_VAL(RV), .SYNC_RST(1'b0), .SPLIT_EN(1'b1)) u_dut (
    .txClk(txClk), .rxClk(rxClk), .oeClk(oeClk), .txRstN(txRstN), .rxRstN(rxRstN),
    .oeRstN(oeRstN), .syncRstN(syncRstN), .txEn(txEn), .rxEn(rxEn),
    .txData(txData), .oeIn(oeIn), .rxData(rxA), .pad(padA));

  bidir_io_cell #(.W(W), .RST_VAL(RV), .SYNC_RST(1'b1), .SPLIT_EN(1'b0)) u_dutSync (
    .txClk(txClk), .rxClk(rxClk), .oeClk(oeClk), .txRstN(txRstN), .rxRstN(rxRstN),
    .oeRstN(oeRstN), .syncRstN(syncRstN), .txEn(txEn), .rxEn(rxEn),
    .txData(txData), .oeIn(oeIn), .rxData(rxB), .pad(padB));

  bidir_io_cell #(.W(W), .RST_VAL(RV), .TX_BYPASS(1'b1), .RX_BYPASS(1'b1), .OE_BYPASS(1'b1)) u_dutByp (
    .txClk(txClk), .rxClk(rxClk), .oeClk(oeClk), .txRstN(txRstN), .rxRstN(rxRstN),
    .oeRstN(oeRstN), .syncRstN(syncRstN), .txEn(txEn), .rxEn(rxEn),
    .txData(txData), .oeIn(oeIn), .rxData(rxC), .pad(padC));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseTx();
    #(CLK_PERIOD/2) txClk = 1;
    #(CLK_PERIOD/2) txClk = 0;
    #1;
  endtask

  task automatic pulseRx();
    #(CLK_PERIOD/2) rxClk = 1;
    #(CLK_PERIOD/2) rxClk = 0;
    #1;
  endtask

  // Bench model of the registered enable: drive the pad only while it is low.
  task automatic pulseOe();
    #(CLK_PERIOD/2) oeClk = 1;
    tbDrvReg = !(oeRstN && oeIn);
    #(CLK_PERIOD/2) oeClk = 0;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    #1;
    txRstN = 0; rxRstN = 0; oeRstN = 0; syncRstN = 0;
    #(CLK_PERIOD/2);
    check("R4 rx async reset value", rxA, RV);
    check("R10 rx bypass", rxC, 4'h0);
    pulseTx(); pulseRx(); pulseOe();
    check("R6 sync reset on rx edge", rxB, RV);
    txRstN = 1; rxRstN = 1; oeRstN = 1; syncRstN = 1;
    #1;
    check("R4 value held after release", rxA, RV);

    tbPadVal = 4'h5; txData = 4'h3; txEn = 1; rxEn = 1; oeIn = 1;
    #1;
    check("R10 tx and oe bypass to pad", padC, 4'h3);
    check("R10 pad bypass to rxData", rxC, 4'h3);
    pulseTx();
    check("R1 rx stage ignores txClk", rxA, RV);
    check("R2 released pad carries outside value", padA, 4'h5);
    pulseRx();
    check("R2 outside value reaches rxData", rxA, 4'h5);
    check("R9 shared enable loads rx", rxB, 4'h5);
    pulseOe();
    check("R1 enable stage on oeClk drives pad", padA, 4'h3);
    check("R11 rx waits for rxClk", rxA, 4'h5);
    pulseRx();
    check("R11 rx after rxClk", rxA, 4'h3);

    for (int v = 0; v < 16; v++) begin
      txData = v[W-1:0];
      pulseTx();
      check("R11 pad one txClk later", padA, v[W-1:0]);
      pulseRx();
      check("R11 rxData one rxClk later", rxA, v[W-1:0]);
      check("R11 sync instance loopback", rxB, v[W-1:0]);
    end

    txData = 4'h9;
    pulseTx();
    check("R11 rxData not yet updated", rxA, 4'hF);
    pulseRx();
    check("R11 loopback word", rxA, 4'h9);

    txEn = 0; rxEn = 0; txData = 4'h6;
    pulseTx();
    check("R8 tx holds without enable", padA, 4'h9);
    check("R8 sync tx holds without enable", padB, 4'h9);
    txEn = 1; rxEn = 0;
    pulseTx();
    pulseRx();
    check("R9 split rx held by rxEn low", rxA, 4'h9);
    check("R9 shared rx follows txEn", rxB, 4'h6);
    txEn = 0; rxEn = 1; txData = 4'h7;
    pulseTx();
    pulseRx();
    check("R8 tx held, R9 split rx loads", rxA, 4'h6);
    check("R9 shared rx ignores rxEn", rxB, 4'h6);

    txRstN = 0;
    #1;
    check("R4 tx async reset without clock", padA, RV);
    check("R7 sync tx ignores txRstN", padB, 4'h6);
    txEn = 1;
    pulseTx();
    check("R8 reset wins over enable", padA, RV);
    check("R7 sync tx loads despite txRstN", padB, 4'h7);
    txRstN = 1;
    rxRstN = 0;
    #1;
    check("R4 rx async reset without clock", rxA, RV);
    check("R7 sync rx ignores rxRstN", rxB, 4'h6);
    rxRstN = 1;

    syncRstN = 0; txData = 4'h2;
    #1;
    check("R6 no change before edge", padB, 4'h7);
    pulseTx();
    check("R5 async tx ignores syncRstN", padA, 4'h2);
    check("R6 sync tx reset on edge", padB, RV);
    pulseRx();
    check("R5 async rx ignores syncRstN", rxA, 4'h2);
    check("R6 sync rx reset on edge", rxB, RV);
    syncRstN = 1;

    tbPadVal = 4'hC;
    oeRstN = 0; tbDrvReg = 1;
    #1;
    check("R3 async clear releases pad", padA, 4'hC);
    pulseOe();
    check("R3 oeClk ignored while cleared", padA, 4'hC);
    pulseRx();
    check("R3 outside value received", rxA, 4'hC);
    oeRstN = 1;
    pulseOe();
    check("R1 enable restored on oeClk", padA, 4'h2);
    check("R2 sync instance drives tx value", padB, RV);

    oeIn = 0;
    #1;
    check("R10 oe bypass releases pad", rxC, 4'hC);
    finishRun();
  end
endmodule